// File: doc/BRIEF.md
# Sticky Round-Robin Request Arbiter

This block arbitrates among N request lines of equal priority and drives a registered one-hot grant vector. It serves requesters in round-robin order, and a grant is sticky: a source that has been granted keeps the grant on every cycle that it keeps its request high. A continuous burst therefore passes through without any other source interleaving. When the holder lowers its request, the grant moves on the next clock edge to the next pending requester above it, wrapping around. The one cycle in which the old holder still owns the grant but no longer requests is the single dead cycle of a switch. If nothing is pending, the grant goes to all-zero.

The block is used in front of a one-hot data multiplexer and ready steering, which it does not contain. A synchronous clear input returns it to its reset state.

The control is a two-state machine. `ST_IDLE` means no grant is out. `ST_HOLD` means exactly one grant is out.
- GRANT (`ST_IDLE` to `ST_HOLD`): any request is seen. The search starts at the stored search start.
- KEEP (`ST_HOLD` to `ST_HOLD`, same holder): the holder still requests.
- ROTATE (`ST_HOLD` to `ST_HOLD`, new holder): the holder dropped its request and another source requests.
- RELEASE (`ST_HOLD` to `ST_IDLE`): no request is pending after the holder dropped.
- CLEAR: forces `ST_IDLE` from any state and sets the search start to 0.

Every grant sets the search start to the index just above the granted source, modulo N.

Top module: `sticky_rr_arbiter`

## Requirements
- R1: `gnt` is all-zero or has exactly one bit set. A bit of `gnt` is set only if the same bit of `req` was high in the cycle before.
- R2: While `clr` is high at a rising edge, `gnt` is all-zero after that edge. The first grant after a clear goes to the lowest-numbered requesting index; bit i of `req` and `gnt` belongs to source i.
- R3: From the idle state, a request is seen at one rising edge and shows on `gnt` right after that edge (one cycle of latency).
- R4: While the holder keeps its `req` bit high, `gnt` does not change, whatever the other request bits do.
- R5: When the holder lowers its request and another bit of `req` is high, the next edge grants the first requesting index, searching upward from holder+1 and wrapping modulo N. No idle cycle is inserted.
- R6: When no `req` bit is high and the holder is not requesting, `gnt` becomes all-zero at the next edge. The search start is kept, so a later grant searches from the last holder+1.
- R7: With N_REQ = 1, `gnt` equals `req` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous clear, active high |
| req | input | N_REQ | Request lines, bit i from source i |
| gnt | output | N_REQ | Registered one-hot or all-zero grant |

## Verification
The bench goes after several corner cases:
- Clear while every line requests. A design that seeded the search start elsewhere would grant a source other than 0 first.
- A holder dropping while lower-numbered sources wait. A design that searched from index 0 would starve the upper sources instead of wrapping.
- A holder dropping while nothing else requests, followed later by a new request. A design that reset its search start on going idle would restart the rotation at 0.
- Bursts held against heavy contention. A design that rotated on every cycle would break the bursts apart.

A second instance with a single requester confirms that the grant is a plain one-cycle delay of the request.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } arb_state_e;

endpackage

// File: rtl/rr_scan.sv
// Rotating first-one search: first set bit of req at or above start, wrapping.
module rr_scan #(
    parameter int N_REQ = 4,
    parameter int IW    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic [N_REQ-1:0] req,
    input  logic [IW-1:0]    start,
    output logic             found,
    output logic [IW-1:0]    pick
);
    localparam int SW = IW + 1;
    localparam logic [SW-1:0] N_W = SW'(N_REQ);

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < N_REQ; k++) begin
            logic [SW-1:0] sum;
            sum = {1'b0, start} + SW'(k);
            if (sum >= N_W) sum = sum - N_W;
            if (!found && req[IW'(sum)]) begin
                found = 1'b1;
                pick  = IW'(sum);
            end
        end
    end

endmodule

// File: rtl/rr_fsm.sv
module rr_fsm
    import rr_arb_pkg::*;
#(
    parameter int N_REQ = 4,
    parameter int IW    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [N_REQ-1:0] req,
    input  logic             found,
    input  logic [IW-1:0]    pick,
    output logic [IW-1:0]    start_q,
    output logic [N_REQ-1:0] gnt
);
    localparam logic [IW:0] LAST = (IW+1)'(N_REQ - 1);

    arb_state_e    state_q, state_d;
    logic [IW-1:0] hold_q, hold_d;
    logic [IW-1:0] start_d;

    function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] i);
        if ({1'b0, i} >= LAST) return '0;
        return i + IW'(1);
    endfunction

    // Next-state logic: GRANT, KEEP, ROTATE, RELEASE
    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        start_d = start_q;
        unique case (state_q)
            ST_IDLE: begin
                if (found) begin            // GRANT
                    state_d = ST_HOLD;
                    hold_d  = pick;
                    start_d = wrap_inc(pick);
                end
            end
            ST_HOLD: begin
                if (req[hold_q]) begin      // KEEP
                    state_d = ST_HOLD;
                end else if (found) begin   // ROTATE
                    hold_d  = pick;
                    start_d = wrap_inc(pick);
                end else begin              // RELEASE
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register (CLEAR)
    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
            start_q <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
            start_q <= start_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (clr || state_d == ST_IDLE) gnt <= '0;
        else                           gnt <= N_REQ'(1) << hold_d;
    end

    a_r1_onehot: assert property (@(posedge clk) disable iff (clr)
        $onehot0(gnt));
    a_r1_only_requesters: assert property (@(posedge clk) disable iff (clr)
        1'b1 |=> ((gnt & ~$past(req)) == '0));
    a_r2_clear_zero: assert property (@(posedge clk)
        clr |=> (gnt == '0));
    a_r4_sticky: assert property (@(posedge clk) disable iff (clr)
        (|(gnt & req)) |=> (gnt == $past(gnt)));
    a_r5_rotate: assert property (@(posedge clk) disable iff (clr)
        ((|gnt) && !(|(gnt & req)) && (|req)) |=> ((|gnt) && gnt != $past(gnt)));
    a_r6_idle: assert property (@(posedge clk) disable iff (clr)
        !(|req) |=> (gnt == '0));
    a_r3_latency: assert property (@(posedge clk) disable iff (clr)
        (gnt == '0 && (|req)) |=> $countones(gnt) == 1);

endmodule

// File: rtl/sticky_rr_arbiter.sv
module sticky_rr_arbiter #(
    parameter int N_REQ = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] gnt
);
    localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1;

    logic          found;
    logic [IW-1:0] pick;
    logic [IW-1:0] start_q;

    rr_scan #(.N_REQ(N_REQ), .IW(IW)) u_scan (
        .req   (req),
        .start (start_q),
        .found (found),
        .pick  (pick)
    );

    rr_fsm #(.N_REQ(N_REQ), .IW(IW)) u_fsm (
        .clk     (clk),
        .clr     (clr),
        .req     (req),
        .found   (found),
        .pick    (pick),
        .start_q (start_q),
        .gnt     (gnt)
    );

endmodule

// File: tb/tb_sticky_rr_arbiter.sv
module tb_sticky_rr_arbiter;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         clr = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] gnt;
    logic [0:0]   req1 = '0;
    logic [0:0]   gnt1;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // model state
    int     m_hold  = -1;
    int     m_start = 0;
    logic [N-1:0] exp_gnt = '0;
    logic [0:0]   exp_g1  = '0;
    string  tag = "R2";

    always #4 clk = ~clk;

    sticky_rr_arbiter #(.N_REQ(N)) dut (.clk(clk), .clr(clr), .req(req), .gnt(gnt));
    sticky_rr_arbiter #(.N_REQ(1)) dut1 (.clk(clk), .clr(clr), .req(req1), .gnt(gnt1));

    function automatic int search(input logic [N-1:0] r, input int s);
        for (int k = 0; k < N; k++) begin
            int i = (s + k) % N;
            if (r[i]) return i;
        end
        return -1;
    endfunction

    task automatic check(input string t, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: gnt actual=%b expected=%b", t, act, exp);
        end
    endtask

    // Drive one cycle: at negedge check prior expectation, set inputs, update model.
    task automatic step(input logic [N-1:0] r, input logic c, input logic r1);
        int nxt;
        @(negedge clk);
        check(tag, gnt, exp_gnt);
        checks++;
        if ($countones(gnt) > 1) begin
            errors++;
            $display("FAIL R1: gnt actual=%b expected=one-hot or zero", gnt);
        end
        checks++;
        if (gnt1 !== exp_g1) begin
            errors++;
            $display("FAIL R7: gnt1 actual=%b expected=%b", gnt1, exp_g1);
        end
        req = r; clr = c; req1 = r1;
        if (c) begin
            m_hold = -1; m_start = 0; exp_gnt = '0; exp_g1 = '0; tag = "R2";
        end else begin
            exp_g1 = r1;
            if (m_hold >= 0 && r[m_hold]) begin
                tag = "R4"; nxt = m_hold;
            end else begin
                nxt = search(r, m_start);
                if (nxt < 0) tag = "R6";
                else if (m_hold >= 0) tag = "R5";
                else if (tag == "R2") tag = "R2";
                else tag = "R3";
            end
            if (nxt >= 0 && nxt != m_hold) m_start = (nxt + 1) % N;
            if (nxt >= 0 && m_hold < 0) m_start = (nxt + 1) % N;
            m_hold  = nxt;
            exp_gnt = (nxt >= 0) ? (N'(1) << nxt) : '0;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
        // R2: clear with all requesting, then first grant to index 0
        step(4'b1111, 1'b1, 1'b1);
        step(4'b1111, 1'b1, 1'b1);
        step(4'b1111, 1'b0, 1'b1);   // R2 grant to 0
        step(4'b1111, 1'b0, 1'b0);   // R4 hold
        step(4'b1110, 1'b0, 1'b1);   // R5 rotate to 1
        step(4'b0101, 1'b0, 1'b1);   // R5 holder 1 dropped -> 2
        step(4'b0001, 1'b0, 1'b0);   // R5 wrap to 0
        step(4'b0000, 1'b0, 1'b0);   // R6 idle
        step(4'b0000, 1'b0, 1'b1);   // R6 stays idle
        step(4'b1001, 1'b0, 1'b1);   // R6 pointer kept: start at 1 -> 3
        step(4'b1111, 1'b0, 1'b0);   // R4
        step(4'b0111, 1'b0, 1'b0);   // R5 wrap from 3 to 0
        step(4'b0000, 1'b0, 1'b0);
        step(4'b0100, 1'b0, 1'b1);   // R3 idle -> grant
        // random phase with sticky-ish requests
        for (int cyc = 0; cyc < 3000; cyc++) begin
            logic [N-1:0] r;
            logic c;
            r = req;
            for (int b = 0; b < N; b++)
                if (($urandom % 4) == 0) r[b] = ~r[b];
            c = (($urandom % 200) == 0);
            step(r, c, 1'($urandom));
        end
        step('0, 1'b0, 1'b0);
        step('0, 1'b0, 1'b0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule